// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit numbers and returns a 2*WIDTH-bit product, spending one clock per bit of the multiplier. A one-cycle `start` pulse, given while the block is idle, captures both operands and zeroes the internal product register. On each following clock the block looks at the lowest bit of the multiplier that has not yet been used. If that bit is one, it adds the multiplicand into the upper half of the product register. If it is zero, it adds nothing. The register is then shifted right by one place, and the carry out of the add becomes the new top bit.

After exactly WIDTH such steps, `done` pulses for one cycle and the full product is visible on `product`. The product stays there until the next accepted start. While an operation is in progress, `busy` is high and any `start` is ignored. The block suits control paths where area matters more than latency, such as address scaling or occasional multiplies in a small datapath. WIDTH defaults to 4.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to `product` = 0, `busy` = 0 and `done` = 0.
- R2: A `start` sampled high while `busy` is low captures both operands. After that edge, `product` reads 0 and `busy` is 1.
- R3: Multiplier bits are consumed least significant first, one per clock. A one bit adds the multiplicand into the upper WIDTH bits of the product register, and a zero bit adds nothing. Either way the register then shifts right by one place. With WIDTH=4, multiplicand 1011 and multiplier 0010, `product` is 0x00 after the first step and 0x58 after the second.
- R4: The carry out of each WIDTH-bit add enters the most significant product bit during the shift, so no carry is lost (1111 x 1111 gives 1110_0001).
- R5: `done` is high in exactly one cycle, WIDTH clock edges after the edge that accepted `start`. In that cycle `busy` is already 0.
- R6: A `start` sampled while `busy` is high has no effect: the running operation completes with its own operands and timing.
- R7: After `done`, `product` holds the finished value unchanged until the next accepted `start`.
- R8: The final product equals multiplicand times multiplier for all operands, for example 1011 x 1001 = 0x63 (99), 1011 x 0111 = 0x4D (77), and a zero operand gives 0.
- R9: A `start` given in the same cycle as `done` is accepted, because `busy` is low then. A new operation begins on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication with the current operands |
| multiplicand | input | WIDTH | Value added on each one bit |
| multiplier | input | WIDTH | Value whose bits select the adds |
| product | output | 2*WIDTH | Product register, partial while busy and final after done |
| busy | output | 1 | High while steps remain |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The hardest situations to reach from the ports are a `start` that arrives in the middle of an operation and a `start` that lands exactly in the `done` cycle. Both depend on landing on a precise clock inside a short window. The bench counts edges from the accepting edge and raises `start` at the second step of a running operation, with different operands. It then checks that the first result and its timing are untouched. It also raises `start` in the very cycle where `done` is seen, and checks that `busy` follows at once. The carry path is driven with all-ones operands, where every step produces a carry out.

// File: rtl/shiftadd_mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes nothing beyond IEEE 1800-2017 enums.
package shiftadd_mul_pkg;
    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/mul_fa_cell.sv
// Module: one-bit full adder cell.
// Sum is the parity of the three inputs; carry is their majority.
// Assumes purely combinational use.
module mul_fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // parity and majority of the three inputs
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/mul_ripple_add.sv
// Module: WIDTH-bit ripple-carry adder built from full adder cells.
// Carry-in of bit 0 is tied low; the final carry is exported.
// Assumes WIDTH >= 1; the delay grows linearly with WIDTH.
module mul_ripple_add #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);
    logic [WIDTH:0] chain;

    // seed the carry chain with zero
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        mul_fa_cell u_fa (
            .x  (op_a[i]),
            .y  (op_b[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    // final carry leaves the adder
    assign carry = chain[WIDTH];
endmodule

// File: rtl/mul_seq_ctrl.sv
// Module: sequencer for the shift-add multiplier.
// Accepts start only when idle, runs STEPS step cycles, then pulses done.
// Assumes synchronous active-low reset and STEPS >= 1.
module mul_seq_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

    mul_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_step;

    // decode accept, step and last-step conditions
    always_comb begin
        load      = (state_q == MS_IDLE) && start;
        step      = (state_q == MS_RUN);
        last_step = step && (cnt_q == LAST_CNT);
    end

    // state, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_step;
            if (load) begin
                state_q <= MS_RUN;
                cnt_q   <= '0;
            end else if (last_step) begin
                state_q <= MS_IDLE;
                cnt_q   <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = (state_q == MS_RUN);
    assign done = done_q;

    // R5: done lasts a single cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy has already dropped when done is seen
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: a start while stepping does not restart the count
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q != LAST_CNT) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));

    // R2: an accepted start makes the block busy on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));
endmodule

// File: rtl/mul_product_reg.sv
// Module: datapath of the shift-add multiplier.
// Holds multiplicand, remaining multiplier bits and the 2*WIDTH product.
// On each step it adds the gated multiplicand into the upper half, then shifts right with the carry.
// Assumes load and step are never high together.
module mul_product_reg #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] upper_sum;
    logic             upper_carry;
    logic [PW:0]      widened;

    // gate the multiplicand by the current multiplier bit
    assign addend = mcand_q & {WIDTH{mplier_q[0]}};

    mul_ripple_add #(.WIDTH(WIDTH)) u_add (
        .op_a  (prod_q[PW-1:WIDTH]),
        .op_b  (addend),
        .sum   (upper_sum),
        .carry (upper_carry)
    );

    // join carry, new upper half and old lower half before the shift
    assign widened = {upper_carry, upper_sum, prod_q[WIDTH-1:0]};

    // operand capture and one add-and-shift per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
        end else if (load) begin
            mcand_q  <= mcand_in;
            mplier_q <= mplier_in;
            prod_q   <= '0;
        end else if (step) begin
            mplier_q <= mplier_q >> 1;
            prod_q   <= widened[PW:1];
        end
    end

    assign prod = prod_q;

    // R2: a load leaves the product register cleared
    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_q == '0));

    // R3: a zero multiplier bit only shifts
    p_zero_bit_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mplier_q[0]) |=> (prod_q == ($past(prod_q) >> 1)));

    // R7: without load or step the product holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(prod_q));
endmodule

// File: rtl/shiftadd_mul.sv
// Module: top of the sequential shift-add multiplier.
// WIDTH-bit unsigned operands give a 2*WIDTH-bit product after WIDTH steps.
// Assumes start is a synchronous pulse; it is ignored while busy.
module shiftadd_mul #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic [2*WIDTH-1:0] product,
    output logic               busy,
    output logic               done
);
    logic load_w;
    logic step_w;

    mul_seq_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load_w),
        .step  (step_w),
        .busy  (busy),
        .done  (done)
    );

    mul_product_reg #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .step      (step_w),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .prod      (product)
    );

    // R1: outputs are idle in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (product == '0 && !busy && !done));
endmodule

// File: tb/shiftadd_mul_bench.sv
`timescale 1ns/1ps
module shiftadd_mul_bench;
    localparam int N = 4;

    // each entry: multiplicand[15:12], multiplier[11:8], product[7:0] (R8)
    localparam logic [15:0] VEC [9] = '{
        16'hB963, 16'hB74D, 16'hFFE1, 16'h0F00, 16'hF000,
        16'h1101, 16'h8840, 16'h7E62, 16'h5A32
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic [2*N-1:0] product;
    logic           busy;
    logic           done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    shiftadd_mul #(.WIDTH(N)) u_shiftadd_mul (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .product      (product),
        .busy         (busy),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue a start pulse and leave the bench just after the accepting edge
    task automatic kick(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // wait for done; returns edges counted since the accepting edge
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [2*N-1:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(product == 0, "R1 product", product, 0);
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);
        rst_n = 1'b1;

        // R8 / R4 / R5: table of vectors
        for (int i = 0; i < 9; i++) begin
            kick(VEC[i][15:12], VEC[i][11:8]);
            check(busy, "R2 busy after accept", busy, 1);
            check(product == 0, "R2 product cleared", product, 0);
            wait_done(cyc);
            check(cyc == N, "R5 latency", cyc, N);
            check(!busy, "R5 busy low at done", busy, 0);
            check(product == VEC[i][7:0], "R8 product", product, VEC[i][7:0]);
            if (VEC[i][15:8] == 8'hFF)
                check(product == 8'hE1, "R4 carry kept", product, 8'hE1);
            @(negedge clk);
            check(!done, "R5 done single cycle", done, 0);
        end

        // R3: partial products for 1011 x 0010
        kick(4'hB, 4'h2);
        @(negedge clk);
        check(product == 8'h00, "R3 zero bit adds nothing", product, 8'h00);
        @(negedge clk);
        check(product == 8'h58, "R3 one bit adds upper half", product, 8'h58);
        wait_done(cyc);
        check(product == 8'h16, "R3 final", product, 8'h16);

        // R7: product holds after done
        held = product;
        repeat (6) @(negedge clk);
        check(product == held, "R7 hold", product, held);
        check(!done && !busy, "R7 idle", {done, busy}, 0);

        // R6: start while busy is ignored
        kick(4'hB, 4'h9);
        @(negedge clk);
        mcand  = 4'hF;
        mplier = 4'hF;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == N, "R6 timing unchanged", cyc, N);
        check(product == 8'h63, "R6 operands unchanged", product, 8'h63);

        // R9: start in the done cycle is accepted
        mcand  = 4'h7;
        mplier = 4'h7;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 accepted in done cycle", busy, 1);
        check(product == 0, "R9 product cleared", product, 0);
        wait_done(cyc);
        check(cyc == N, "R9 latency", cyc, N);
        check(product == 8'h31, "R9 product", product, 8'h31);

        // R1: reset in the middle of an operation
        kick(4'hF, 4'hF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(product == 0 && !busy && !done, "R1 reset mid-run", {product, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule